// File: doc/BRIEF.md
# Access-Overlay Permission Register with Check Port

This block holds one 64-bit control word made of sixteen 4-bit overlay fields and judges memory accesses against them. Software at the most privileged level reads and writes the word through a system-register style request port. The request names the register with a packed selector and carries the requester's privilege level. A request from a lower level is refused with an undefined-instruction flag and leaves the word as it was.

The check port takes a 4-bit overlay index and an access kind, picks the field that the index names, and raises a deny flag when that field does not grant the kind. Two mode inputs shape the result. One says whether the wide (128-bit) translation format is active, which is the only case in which the upper eight fields exist. The other turns the overlay on or off. Checks always use the word as it stands in the same cycle. There is no cached copy.

Top module: `ovl_guard`

## Requirements
- R1: After synchronous reset the word is all zeros, so a read returns 0 and every check with the overlay enabled is denied.
- R2: A field value with bit 3 clear grants by bit: bit 0 grants read, bit 1 grants execute and bit 2 grants write. A check is denied when the bit for its own kind is clear, whatever the other bits hold.
- R3: A field value with bit 3 set grants nothing, and every kind is denied.
- R4: While `wide_fmt` is low, fields 8 to 15 (bits 63:32) read as zero, checks on indices 8 to 15 are denied, and a write leaves the stored upper half unchanged. The stored upper half becomes visible again once `wide_fmt` is high.
- R5: While `ovl_en` is low, `chk_deny` is low for every index and kind.
- R6: A request that matches the selector from privilege level 0, 1 or 2 raises `acc_undef` in the same cycle, returns `acc_rdata` = 0 and does not change the word.
- R7: The selector is the 16-bit value {op0=2'b11, op1=3'b110, crn=4'b1010, crm=4'b0010, op2=3'b100} = 16'hF514, and the same value serves read and write. A request with any other selector is not claimed: `acc_ready` and `acc_undef` stay low, `acc_rdata` is 0 and the word keeps its value.
- R8: A write accepted at privilege level 3 takes effect on the next rising edge. A check in the same cycle as the write still sees the old contents, and a check in the following cycle sees the new contents.
- R9: `acc_ready` is high in the same cycle as any matching request. A matching read at level 3 returns the masked word on `acc_rdata` in that cycle. In every other case `acc_rdata` is 0.
- R10: `chk_kind` encodes 0 = read, 1 = write, 2 = execute. The value 3 is always denied while the overlay is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_fmt | input | 1 | Wide translation format active; enables fields 8 to 15 |
| ovl_en | input | 1 | Overlay enable; when low, every check is allowed |
| acc_valid | input | 1 | Register access request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 16 | Packed register selector |
| acc_pl | input | 2 | Privilege level of the requester (0 to 3) |
| acc_wdata | input | 64 | Write data |
| acc_ready | output | 1 | Request claimed this cycle |
| acc_rdata | output | 64 | Read data (masked word) |
| acc_undef | output | 1 | Request refused as undefined |
| chk_idx | input | 4 | Overlay field index |
| chk_kind | input | 2 | Access kind |
| chk_deny | output | 1 | Access not permitted |

## Verification
If the stored word is corrupted, for example by a refused or unclaimed write, the damage shows at `acc_rdata` on the next level-3 read. It also shows at `chk_deny` in the first cycle after the bad edge for any index and kind that the corrupted bits govern. Because the check path holds no state of its own, a wrong field select or a wrong grant decode shows up in the same cycle as the check input that exposes it. A masking fault in the upper half shows up only when `wide_fmt` is toggled, so the bench reads and checks under both settings after the same write.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int FIELD_W     = 4;
    localparam int N_FIELDS    = 16;
    localparam int BASE_FIELDS = 8;
    localparam int WORD_W      = FIELD_W * N_FIELDS;
    localparam int IDX_W       = $clog2(N_FIELDS);
    localparam int SEL_W       = 16;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_BAD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PL_0 = 2'd0,
        PL_1 = 2'd1,
        PL_2 = 2'd2,
        PL_3 = 2'd3
    } priv_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sel_t;

    localparam sel_t OVL_SEL = '{op0: 2'b11, op1: 3'b110, crn: 4'b1010,
                                 crm: 4'b0010, op2: 3'b100};

    // Bit positions inside a field that carry each grant.
    localparam int BIT_RD  = 0;
    localparam int BIT_EX  = 1;
    localparam int BIT_WR  = 2;
    localparam int BIT_RSV = 3;

    function automatic logic field_grants(logic [FIELD_W-1:0] f, kind_e k);
        logic g;
        if (f[BIT_RSV]) begin
            g = 1'b0;
        end else begin
            unique case (k)
                KIND_READ:  g = f[BIT_RD];
                KIND_WRITE: g = f[BIT_WR];
                KIND_EXEC:  g = f[BIT_EX];
                default:    g = 1'b0;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/ovl_store.sv
module ovl_store
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_fmt,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  sel_t              acc_sel,
    input  priv_e             acc_pl,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              acc_undef,
    output logic [WORD_W-1:0] view
);

    logic [WORD_W-1:0] stored;
    logic [WORD_W-1:0] stored_nx;
    logic              hit;
    logic              top_pl;
    logic              wr_ok;
    logic              rd_ok;

    assign hit    = acc_valid && (acc_sel == OVL_SEL);
    assign top_pl = (acc_pl == PL_3);
    assign wr_ok  = hit && top_pl && acc_write;
    assign rd_ok  = hit && top_pl && !acc_write;

    assign acc_ready = hit;
    assign acc_undef = hit && !top_pl;
    assign acc_rdata = rd_ok ? view : '0;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_lane
        localparam int LO = i * FIELD_W;
        if (i < BASE_FIELDS) begin : g_base
            assign view[LO +: FIELD_W]      = stored[LO +: FIELD_W];
            assign stored_nx[LO +: FIELD_W] = wr_ok ? acc_wdata[LO +: FIELD_W]
                                                    : stored[LO +: FIELD_W];
        end else begin : g_wide
            assign view[LO +: FIELD_W]      = wide_fmt ? stored[LO +: FIELD_W] : '0;
            assign stored_nx[LO +: FIELD_W] = (wr_ok && wide_fmt) ? acc_wdata[LO +: FIELD_W]
                                                                  : stored[LO +: FIELD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stored <= '0;
        else     stored <= stored_nx;
    end

    // R1: reset leaves an all-zero word
    a_r1_reset_zero: assert property (@(posedge clk) $fell(rst) |-> (view == '0));

    // R6: a refused request keeps the word
    a_r6_undef_keeps: assert property (@(posedge clk) disable iff (rst)
        acc_undef |=> $stable(stored));

    // R7: an unclaimed request keeps the word
    a_r7_unclaimed_keeps: assert property (@(posedge clk) disable iff (rst)
        !acc_ready |=> $stable(stored));

    // R4: upper half is hidden while the wide format is off
    a_r4_upper_hidden: assert property (@(posedge clk) disable iff (rst)
        !wide_fmt |-> (acc_rdata[WORD_W-1:BASE_FIELDS*FIELD_W] == '0));

    // R9: data only leaves on a claimed, non-refused read
    a_r9_rdata_gated: assert property (@(posedge clk) disable iff (rst)
        (!acc_ready || acc_undef || acc_write) |-> (acc_rdata == '0));

endmodule

// File: rtl/ovl_judge.sv
module ovl_judge
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ovl_en,
    input  logic [WORD_W-1:0] view,
    input  logic [IDX_W-1:0]  chk_idx,
    input  kind_e             chk_kind,
    output logic              chk_deny
);

    logic [FIELD_W-1:0] field;

    assign field    = view[chk_idx * FIELD_W +: FIELD_W];
    assign chk_deny = ovl_en && !field_grants(field, chk_kind);

    // R5: a disabled overlay never denies
    a_r5_disabled_allows: assert property (@(posedge clk) disable iff (rst)
        !ovl_en |-> !chk_deny);

    // R3: reserved encodings deny every kind
    a_r3_reserved_denies: assert property (@(posedge clk) disable iff (rst)
        (ovl_en && field[BIT_RSV]) |-> chk_deny);

    // R10: the spare kind code is always denied
    a_r10_bad_kind: assert property (@(posedge clk) disable iff (rst)
        (ovl_en && chk_kind == KIND_BAD) |-> chk_deny);

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_fmt,
    input  logic              ovl_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [1:0]        acc_pl,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              acc_undef,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [1:0]        chk_kind,
    output logic              chk_deny
);

    logic [WORD_W-1:0] view;

    ovl_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wide_fmt  (wide_fmt),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (sel_t'(acc_sel)),
        .acc_pl    (priv_e'(acc_pl)),
        .acc_wdata (acc_wdata),
        .acc_ready (acc_ready),
        .acc_rdata (acc_rdata),
        .acc_undef (acc_undef),
        .view      (view)
    );

    ovl_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .ovl_en   (ovl_en),
        .view     (view),
        .chk_idx  (chk_idx),
        .chk_kind (kind_e'(chk_kind)),
        .chk_deny (chk_deny)
    );

    // R2: a granted read is never denied
    a_r2_read_grant: assert property (@(posedge clk) disable iff (rst)
        (ovl_en && chk_kind == 2'd0 && view[chk_idx*FIELD_W +: FIELD_W] == 4'b0001) |-> !chk_deny);

endmodule

// File: tb/sim_ovl_guard.sv
module sim_ovl_guard;

    localparam logic [15:0] SEL_OK  = 16'hF514;
    localparam logic [15:0] SEL_BAD = 16'hF515;

    logic        clk = 1'b0;
    logic        rst;
    logic        wide_fmt, ovl_en, acc_valid, acc_write;
    logic [15:0] acc_sel;
    logic [1:0]  acc_pl;
    logic [63:0] acc_wdata;
    logic        acc_ready, acc_undef, chk_deny;
    logic [63:0] acc_rdata;
    logic [3:0]  chk_idx;
    logic [1:0]  chk_kind;

    int vectors = 0;
    int misses  = 0;
    logic [63:0] m_word;

    always #5 clk = ~clk;

    ovl_guard u0 (
        .clk(clk), .rst(rst), .wide_fmt(wide_fmt), .ovl_en(ovl_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_pl(acc_pl), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
        .acc_rdata(acc_rdata), .acc_undef(acc_undef), .chk_idx(chk_idx),
        .chk_kind(chk_kind), .chk_deny(chk_deny)
    );

    function automatic bit exp_deny(logic [63:0] w, bit ext, bit en, int idx, int kind);
        int f;
        if (!en) return 0;
        if (!ext && idx >= 8) f = 0;
        else f = int'((w >> (idx * 4)) & 64'hF);
        if (f >= 8) return 1;
        case (kind)
            0: return (f % 2) == 0;
            1: return ((f / 4) % 2) == 0;
            2: return ((f / 2) % 2) == 0;
            default: return 1;
        endcase
    endfunction

    task automatic step(string tag, bit v, bit w, logic [15:0] sel, int pl,
                        logic [63:0] wd, bit ext, bit en, int idx, int kind);
        bit          match;
        bit          e_ready, e_undef, e_deny;
        logic [63:0] e_rdata;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_sel = sel; acc_pl = 2'(pl);
        acc_wdata = wd; wide_fmt = ext; ovl_en = en;
        chk_idx = 4'(idx); chk_kind = 2'(kind);
        #1;
        match   = v && (sel == SEL_OK);
        e_ready = match;
        e_undef = match && pl < 3;
        e_rdata = (match && pl == 3 && !w) ? (ext ? m_word : (m_word & 64'h0000_0000_FFFF_FFFF)) : 64'h0;
        e_deny  = exp_deny(m_word, ext, en, idx, kind);
        vectors++;
        if (acc_ready !== e_ready || acc_undef !== e_undef ||
            acc_rdata !== e_rdata || chk_deny !== e_deny) begin
            misses++;
            $display("FAIL %s: ready/undef/rdata/deny actual %b %b %h %b expected %b %b %h %b",
                     tag, acc_ready, acc_undef, acc_rdata, chk_deny,
                     e_ready, e_undef, e_rdata, e_deny);
        end
        @(posedge clk);
        if (rst) m_word = 64'h0;
        else if (match && pl == 3 && w) begin
            m_word[31:0] = wd[31:0];
            if (ext) m_word[63:32] = wd[63:32];
        end
    endtask

    task automatic wr3(string tag, logic [63:0] wd, bit ext);
        step(tag, 1, 1, SEL_OK, 3, wd, ext, 1, 0, 0);
    endtask

    task automatic rd3(string tag, bit ext);
        step(tag, 1, 0, SEL_OK, 3, 64'h0, ext, 1, 0, 0);
    endtask

    task automatic sweep(string tag, bit ext, bit en);
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++)
                step(tag, 0, 0, SEL_OK, 3, 64'h0, ext, en, i, k);
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        m_word = 64'h0;
        rst = 1'b1;
        acc_valid = 0; acc_write = 0; acc_sel = 0; acc_pl = 0; acc_wdata = 0;
        wide_fmt = 1; ovl_en = 1; chk_idx = 0; chk_kind = 0;
        repeat (2) @(posedge clk);
        step("R1 in reset", 0, 0, SEL_OK, 3, 64'h0, 1, 1, 0, 0);
        rst = 1'b0;
        // R1: zero word after reset, all checks denied
        rd3("R1 read after reset", 1);
        sweep("R1 sweep after reset", 1, 1);

        // R2, R3, R10: every encoding in one word, wide format on
        wr3("R9 write", 64'hFEDC_BA98_7654_3210, 1);
        rd3("R9 read back", 1);
        sweep("R2 R3 R10 sweep", 1, 1);

        // R4: upper half hidden and read as zero
        rd3("R4 read narrow", 0);
        sweep("R4 sweep narrow", 0, 1);
        wr3("R4 narrow write", 64'h0123_4567_7777_7777, 0);
        rd3("R4 upper kept", 1);
        rd3("R4 upper masked", 0);

        // R5: overlay disabled
        sweep("R5 disabled", 1, 0);

        // R6: lower privilege levels are refused
        for (int p = 0; p < 3; p++) begin
            step("R6 low write", 1, 1, SEL_OK, p, 64'h0, 1, 1, 0, 0);
            step("R6 low read", 1, 0, SEL_OK, p, 64'h0, 1, 1, 0, 0);
        end
        rd3("R6 word unchanged", 1);

        // R7: other selectors are not claimed
        step("R7 bad sel write", 1, 1, SEL_BAD, 3, 64'h0, 1, 1, 0, 0);
        step("R7 bad sel read", 1, 0, 16'h0000, 3, 64'h0, 1, 1, 0, 0);
        step("R7 invalid write", 0, 1, SEL_OK, 3, 64'h0, 1, 1, 0, 0);
        rd3("R7 word unchanged", 1);

        // R8: check in the write cycle sees old value, next cycle sees new
        wr3("R8 setup", 64'h0, 1);
        step("R8 same cycle", 1, 1, SEL_OK, 3, 64'h0000_0000_0000_0001, 1, 1, 0, 0);
        step("R8 next cycle", 0, 0, SEL_OK, 3, 64'h0, 1, 1, 0, 0);

        // Mixed patterns with pseudo-random stimulus
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 400; n++) begin
            bit v, w, ext, en;
            int pl;
            logic [63:0] wd;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            v   = lfsr[0] | lfsr[5];
            w   = lfsr[1];
            pl  = int'(lfsr[3:2]) | (lfsr[7] ? 3 : 0);
            ext = lfsr[4] | lfsr[9];
            en  = lfsr[6] | lfsr[8];
            wd  = {lfsr, ~lfsr ^ {lfsr[15:0], lfsr[31:16]}};
            step("R2 R4 R8 mixed", v, w, lfsr[10] ? SEL_OK : SEL_BAD, pl, wd, ext, en,
                 int'(lfsr[14:11]), int'(lfsr[16:15]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule